// File: doc/BRIEF.md
# Bit-Addressable Bidirectional I/O Port

An eight-pin general purpose port for a microcontroller-class subsystem. Each pin has a direction bit and an output latch bit. Software writes the latch or the direction as whole bytes, and it can set or clear a single latch bit. Reads return the pin levels after a two-flop synchronizer. The port does not return the latch contents on a read.

A single-bit set or clear is a read-modify-write. It takes the synchronized pin levels, changes the addressed bit and stores the whole byte into the latch. An output pin that an outside driver holds at the wrong level therefore has its latch bit rewritten. This hazard is intentional and the port keeps it.

A change on any pin configured as input raises a wake request at once. It also sets a sticky change flag, measured against the pin levels captured at the last read. Any pin can be handed to a peripheral, whose enable and data then replace that pin's direction and latch.

Top module: `gpio_bitop_port`

## Requirements
- R1: After reset every direction bit is 1 (input), so `pin_oe` is 0x00. The latch is 0x00, `pin_out` is 0x00, and `chg_flag` and `wake_req` are 0.
- R2: A `dir_wr` strobe loads `wr_data` into the direction register. A direction bit of 1 makes the pin an input and 0 makes it an output. `pin_oe` equals the inverted register, one cycle after the strobe, for pins that are not overridden. Writing 0x00 turns all pins into outputs.
- R3: A `lat_wr` strobe loads `wr_data` into the latch. `pin_out` shows the latch one cycle later for pins that are not overridden, whatever their direction.
- R4: `rd_data` equals `pin_in` delayed by two clock edges through the synchronizer.
- R5: A `bit_op` strobe loads the latch with the synchronized pin byte, with bit `bit_idx` forced to 1 when `bit_set` is 1 or to 0 when `bit_set` is 0. The result appears one cycle after the strobe. When `lat_wr` is asserted in the same cycle, the byte write wins.
- R6: If an outside source holds an output pin at a level other than its latch bit, a `bit_op` on a different bit copies that outside level into the latch. The copied value stays after the outside source lets go.
- R7: `wake_req` is high in the same cycle that the synchronized level of any input-configured pin differs from the snapshot. `chg_flag` goes high one cycle later. Pins configured as outputs never cause either signal.
- R8: `chg_flag` stays high until `chg_clr` is asserted. A clear has no effect while a difference is still present. An `rd_en` strobe copies the current synchronized pins into the snapshot.
- R9: When `ovr_en[i]` is 1, pin i drives `pin_oe[i]` from `ovr_oe[i]` and `pin_out[i]` from `ovr_dout[i]`. This happens in the same cycle and leaves all other pins unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lat_wr | input | 1 | Write `wr_data` to the output latch |
| dir_wr | input | 1 | Write `wr_data` to the direction register |
| wr_data | input | 8 | Write data for the byte writes |
| bit_op | input | 1 | Single-bit read-modify-write of the latch |
| bit_set | input | 1 | 1 sets the addressed bit, 0 clears it |
| bit_idx | input | 3 | Addressed bit number |
| rd_en | input | 1 | Port read; refreshes the change snapshot |
| rd_data | output | 8 | Synchronized pin levels |
| chg_clr | input | 1 | Clear the change flag |
| chg_flag | output | 1 | Sticky input-change flag |
| wake_req | output | 1 | Live input-change indication |
| ovr_en | input | 8 | Per-pin peripheral takeover |
| ovr_oe | input | 8 | Peripheral output enable |
| ovr_dout | input | 8 | Peripheral output data |
| pin_in | input | 8 | Pad input levels |
| pin_oe | output | 8 | Pad output enable, 1 drives |
| pin_out | output | 8 | Pad output data |

## Verification
The outputs are due at fixed delays after a stimulus:
- `pin_oe` and `pin_out` change one edge after a byte write or bit operation. Override effects appear in the same cycle.
- `rd_data` and `wake_req` follow a pad change by two edges, and `chg_flag` follows it by three.

The bench models the pads as loopback with an optional outside force. It waits three edges after any latch change before it starts a bit operation, so the synchronized bytes have settled. Each result is sampled on the falling edge after its due edge. Expected latch values are computed as masks over the pin bytes. The sweeps cover all 256 input bytes, all bit indices with both polarities over several patterns, and the direction and latch patterns.

// File: rtl/gpio_bitop_pkg.sv
// Shared constants for the bit-addressable I/O port.
// Assumes: port widths of at least 2 pins.
package gpio_bitop_pkg;
    localparam int unsigned PORT_W = 8;
    typedef enum logic {
        BIT_CLEAR = 1'b0,
        BIT_SET   = 1'b1
    } bit_cmd_e;
endpackage

// File: rtl/gpio_sync.sv
// Multi-stage synchronizer for the pad input byte.
// Assumes: STAGES >= 1; the reset value of every stage is all zeros.
module gpio_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    // first stage samples the asynchronous pads
    always_ff @(posedge clk) begin
        if (!rst_n) stg_q[0] <= '0;
        else        stg_q[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // each further stage retimes the previous one
        always_ff @(posedge clk) begin
            if (!rst_n) stg_q[s] <= '0;
            else        stg_q[s] <= stg_q[s-1];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
// Direction register and output latch, with byte writes and a single-bit
// read-modify-write that takes the synchronized pin byte as its source.
// Assumes: bit_idx < W; a byte write has priority over a bit operation.
module gpio_regs
    import gpio_bitop_pkg::*;
#(
    parameter int unsigned W  = 8,
    localparam int unsigned IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lat_wr,
    input  logic          dir_wr,
    input  logic [W-1:0]  wr_data,
    input  logic          bit_op,
    input  logic          bit_set,
    input  logic [IW-1:0] bit_idx,
    input  logic [W-1:0]  pins_sync,
    output logic [W-1:0]  lat_q,
    output logic [W-1:0]  dir_q
);
    logic [W-1:0] bit_mask;
    logic [W-1:0] rmw_val;

    // build the modified byte from the sampled pins, not from the latch
    always_comb begin
        bit_mask = {{(W-1){1'b0}}, 1'b1} << bit_idx;
        rmw_val  = (bit_cmd_e'(bit_set) == BIT_SET) ? (pins_sync | bit_mask)
                                                    : (pins_sync & ~bit_mask);
    end

    // output latch: byte write first, then bit operation
    always_ff @(posedge clk) begin
        if (!rst_n)      lat_q <= '0;
        else if (lat_wr) lat_q <= wr_data;
        else if (bit_op) lat_q <= rmw_val;
    end

    // direction register, 1 = input
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '1;
        else if (dir_wr) dir_q <= wr_data;
    end

    // R3
    byte_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lat_wr |=> lat_q == $past(wr_data));
    // R5
    bit_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_op && !lat_wr) |=> lat_q[$past(bit_idx)] == $past(bit_set));
    // R6
    bit_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_op && !lat_wr) |=> (lat_q & ~$past(bit_mask)) == ($past(pins_sync) & ~$past(bit_mask)));
    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dir_wr |=> dir_q == $past(wr_data));
endmodule

// File: rtl/gpio_chg.sv
// Input change detector: compares synchronized pins on input-configured
// positions against a snapshot taken at each port read.
// Assumes: in_mask has 1 for every pin currently configured as input.
module gpio_chg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_sync,
    input  logic [W-1:0] in_mask,
    input  logic         rd_en,
    input  logic         chg_clr,
    output logic         chg_flag,
    output logic         wake_req
);
    logic [W-1:0] snap_q;
    logic [W-1:0] diff;
    logic         flag_q;

    // difference on input pins only
    always_comb begin
        diff     = (pins_sync ^ snap_q) & in_mask;
        wake_req = |diff;
    end

    // snapshot of the pins at the last read
    always_ff @(posedge clk) begin
        if (!rst_n)     snap_q <= '0;
        else if (rd_en) snap_q <= pins_sync;
    end

    // sticky flag; a present difference outweighs a clear
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= (flag_q & ~chg_clr) | wake_req;
    end

    assign chg_flag = flag_q;

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |=> chg_flag);
    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_flag && !chg_clr) |=> chg_flag);
    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_clr && !wake_req) |=> !chg_flag);
    // R8
    snap_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $stable(pins_sync)) |=> (snap_q == pins_sync));
endmodule

// File: rtl/gpio_bitop_port.sv
// Top of the bit-addressable I/O port: synchronizer, registers, change
// detector and the per-pin peripheral override mux.
// Assumes: pad buffers outside; pin_oe = 1 means the pad drives pin_out.
module gpio_bitop_port
    import gpio_bitop_pkg::*;
#(
    parameter int unsigned W    = PORT_W,
    parameter int unsigned SYNC = 2,
    localparam int unsigned IW  = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lat_wr,
    input  logic          dir_wr,
    input  logic [W-1:0]  wr_data,
    input  logic          bit_op,
    input  logic          bit_set,
    input  logic [IW-1:0] bit_idx,
    input  logic          rd_en,
    output logic [W-1:0]  rd_data,
    input  logic          chg_clr,
    output logic          chg_flag,
    output logic          wake_req,
    input  logic [W-1:0]  ovr_en,
    input  logic [W-1:0]  ovr_oe,
    input  logic [W-1:0]  ovr_dout,
    input  logic [W-1:0]  pin_in,
    output logic [W-1:0]  pin_oe,
    output logic [W-1:0]  pin_out
);
    logic [W-1:0] pins_sync;
    logic [W-1:0] lat_q;
    logic [W-1:0] dir_q;

    gpio_sync #(.W(W), .STAGES(SYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pins_sync)
    );

    gpio_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .lat_wr(lat_wr), .dir_wr(dir_wr),
        .wr_data(wr_data), .bit_op(bit_op), .bit_set(bit_set),
        .bit_idx(bit_idx), .pins_sync(pins_sync), .lat_q(lat_q), .dir_q(dir_q)
    );

    for (genvar i = 0; i < W; i++) begin : g_pin
        // per-pin choice between port registers and peripheral
        always_comb begin
            pin_oe[i]  = ovr_en[i] ? ovr_oe[i]   : ~dir_q[i];
            pin_out[i] = ovr_en[i] ? ovr_dout[i] : lat_q[i];
        end
    end

    gpio_chg #(.W(W)) u_chg (
        .clk(clk), .rst_n(rst_n), .pins_sync(pins_sync), .in_mask(~pin_oe),
        .rd_en(rd_en), .chg_clr(chg_clr), .chg_flag(chg_flag), .wake_req(wake_req)
    );

    assign rd_data = pins_sync;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (dir_q == '1) && (lat_q == '0) && !chg_flag);
    // R7
    out_pins_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe == '1) |-> !wake_req);
endmodule

// File: tb/sim_gpio_bitop_port.sv
module sim_gpio_bitop_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lat_wr = 0, dir_wr = 0, bit_op = 0, bit_set = 0, rd_en = 0, chg_clr = 0;
    logic [7:0] wr_data = 0;
    logic [2:0] bit_idx = 0;
    logic [7:0] rd_data, pin_oe, pin_out, pin_in;
    logic       chg_flag, wake_req;
    logic [7:0] ovr_en = 0, ovr_oe = 0, ovr_dout = 0;
    logic [7:0] ext_val = 0, frc_en = 0, frc_val = 0;
    int         n_chk = 0, n_bad = 0;
    bit         done = 0;

    always #4 clk = ~clk;

    // pad model: forced value, else loopback of driven pins, else outside level
    assign pin_in = (frc_en & frc_val) |
                    (~frc_en & ((pin_oe & pin_out) | (~pin_oe & ext_val)));

    gpio_bitop_port u0 (
        .clk(clk), .rst_n(rst_n), .lat_wr(lat_wr), .dir_wr(dir_wr),
        .wr_data(wr_data), .bit_op(bit_op), .bit_set(bit_set), .bit_idx(bit_idx),
        .rd_en(rd_en), .rd_data(rd_data), .chg_clr(chg_clr), .chg_flag(chg_flag),
        .wake_req(wake_req), .ovr_en(ovr_en), .ovr_oe(ovr_oe), .ovr_dout(ovr_dout),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    task automatic tick(int n = 1);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
        end
    endtask

    task automatic wr_lat(logic [7:0] v);
        wr_data = v; lat_wr = 1; tick(); lat_wr = 0;
    endtask

    task automatic wr_dir(logic [7:0] v);
        wr_data = v; dir_wr = 1; tick(); dir_wr = 0;
    endtask

    task automatic do_bit(logic [2:0] k, logic s);
        bit_idx = k; bit_set = s; bit_op = 1; tick(); bit_op = 0;
    endtask

    task automatic pulse_rd();  rd_en = 1;  tick(); rd_en = 0;  endtask
    task automatic pulse_clr(); chg_clr = 1; tick(); chg_clr = 0; endtask

    initial begin
        logic [7:0] pats [4] = '{8'h00, 8'hFF, 8'hA5, 8'h3C};
        logic [7:0] e;
        @(negedge clk); tick(2); rst_n = 1; tick();
        // R1 reset state
        chk("R1 pin_oe", pin_oe, 8'h00);
        chk("R1 pin_out", pin_out, 8'h00);
        chk("R1 chg_flag", {7'b0, chg_flag}, 8'h00);
        chk("R1 wake_req", {7'b0, wake_req}, 8'h00);

        // R4 all input bytes, all pins inputs
        for (int v = 0; v < 256; v++) begin
            ext_val = 8'(v); tick(2);
            chk("R4 rd_data", rd_data, 8'(v));
        end
        ext_val = 0; tick(3); pulse_rd(); pulse_clr();

        // R2 direction patterns, R3 latch patterns
        for (int v = 0; v < 256; v += 17) begin
            wr_dir(8'(v)); chk("R2 pin_oe", pin_oe, ~8'(v));
            wr_lat(8'(v)); chk("R3 pin_out", pin_out, 8'(v));
        end
        wr_dir(8'h00); chk("R2 all outputs", pin_oe, 8'hFF);

        // R5 every bit, both commands, several starting bytes
        for (int p = 0; p < 4; p++)
            for (int k = 0; k < 8; k++)
                for (int s = 0; s < 2; s++) begin
                    wr_lat(pats[p]); tick(3);
                    e = (s == 1) ? (pats[p] | (8'h01 << k)) : (pats[p] & ~(8'h01 << k));
                    do_bit(3'(k), s[0]);
                    chk("R5 bit op", pin_out, e);
                end
        // R5 byte write wins over bit op in the same cycle
        wr_lat(8'h00); tick(3);
        wr_data = 8'h5A; lat_wr = 1; bit_op = 1; bit_idx = 0; bit_set = 1; tick();
        lat_wr = 0; bit_op = 0;
        chk("R5 priority", pin_out, 8'h5A);

        // R6 outside force on pin 0 corrupts latch via set of bit 7
        wr_lat(8'hF0); frc_en = 8'h01; frc_val = 8'h01; tick(3);
        do_bit(3'd7, 1'b1);
        chk("R6 captured", pin_out, 8'hF1);
        frc_en = 0; tick(3);
        chk("R6 persists", pin_out, 8'hF1);

        // R7 change on an input pin
        wr_dir(8'hFF); ext_val = 0; tick(3); pulse_rd(); pulse_clr();
        chk("R7 quiet flag", {7'b0, chg_flag}, 8'h00);
        ext_val = 8'h08; tick(2);
        chk("R7 wake", {7'b0, wake_req}, 8'h01);
        chk("R7 flag late", {7'b0, chg_flag}, 8'h00);
        tick();
        chk("R7 flag", {7'b0, chg_flag}, 8'h01);
        // R8 clear ignored while difference persists, then read and clear
        pulse_clr();
        chk("R8 clr ignored", {7'b0, chg_flag}, 8'h01);
        pulse_rd();
        chk("R8 wake after read", {7'b0, wake_req}, 8'h00);
        chk("R8 sticky", {7'b0, chg_flag}, 8'h01);
        pulse_clr();
        chk("R8 cleared", {7'b0, chg_flag}, 8'h00);
        // R7 output pins do not count
        wr_lat(8'h00); wr_dir(8'h0F); tick(3); pulse_rd(); pulse_clr();
        wr_lat(8'hF0); tick(4);
        chk("R7 out wake", {7'b0, wake_req}, 8'h00);
        chk("R7 out flag", {7'b0, chg_flag}, 8'h00);
        chk("R4 mixed read", rd_data, 8'hF8);

        // R9 peripheral override of pin 2
        wr_dir(8'hFF); wr_lat(8'h00);
        ovr_en = 8'h04; ovr_oe = 8'h04; ovr_dout = 8'h04; #1;
        chk("R9 oe", pin_oe, 8'h04);
        chk("R9 out", pin_out, 8'h04);
        wr_dir(8'h00); ovr_oe = 8'h00; #1;
        chk("R9 oe off", pin_oe, 8'hFB);
        wr_lat(8'hFF); ovr_dout = 8'h00; #1;
        chk("R9 out masked", pin_out, 8'hFB);
        ovr_en = 0; #1;
        chk("R9 release", pin_out, 8'hFF);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule